// File: doc/BRIEF.md
# Serial Bitstream Loader for SRAM-Based FPGAs

This block brings up an SRAM-based FPGA after power-on. It reads a configuration image from a byte-wide ROM and feeds it into the target over the passive serial protocol. A host CPU issues a single start command. The loader then does the following in order:

- pulses the target's configuration-reset pin low;
- waits for the target's status pin to go low and then return high;
- shifts the image out one bit per serial clock, least significant bit first;
- watches for the target's done pin.

A two-bit status word tells the host whether the load is idle, running, finished or failed.

Two conditions are handled without host involvement. If the target pulls its status pin low during the transfer, the loader pulses the reset pin again and restarts the whole image from address zero. Once the target reports done, the loader gives a fixed number of extra serial clocks so the target can finish its initialisation. If the done pin has not risen within a bounded number of padding clocks after the last byte, the load ends in the error state.

The target's status and done pins are asynchronous to the loader. Both pass through a synchroniser before any decision uses them.

Top module: `cfg_loader`

## Requirements
- R1: After reset, the status is idle, the configuration-reset output (`ncfg_o`) is high and `dclk_o` is low. With no start command, nothing changes.
- R2: A one-cycle `host_start` begins a load from the idle, done or error state. A start that arrives while the loader is busy is ignored and causes no second reset pulse.
- R3: A load begins by driving `ncfg_o` low for exactly PULSE_CYC system clocks.
- R4: After `ncfg_o` returns high, the first rising edge of `dclk_o` comes only after two conditions hold. First, `nstatus_i` has been seen low and then high. Second, at least GAP_CYC system clocks have passed since the rising edge of `ncfg_o`.
- R5: `dclk_o` has a period of DCLK_DIV system clocks: low for the first half, high for the second. `data0_o` changes only while `dclk_o` is low, so it is stable on every rising edge.
- R6: The image is IMAGE_BYTES bytes long. It is read from ROM address 0 upward, and each byte is sent least significant bit first, one bit per `dclk_o` rising edge.
- R7: When `cdone_i` is seen high at a serial-clock boundary, data transfer stops. INIT_CLKS more serial clocks follow and the status becomes done. The target's done rising can be seen late by at most one boundary, so the target sees INIT_CLKS or INIT_CLKS+1 rising edges after it raises `cdone_i`.
- R8: If `nstatus_i` goes low while data or padding is being clocked, the loader pulses `ncfg_o` low again. The whole image is then reloaded from address 0, and the load still completes.
- R9: If `cdone_i` is still low after the last image bit, exactly TAIL_CLKS padding clocks are given and the status becomes error.
- R10: `host_status` encodes 00 idle, 01 busy, 10 done and 11 error. It is busy whenever `ncfg_o` is low. Done and error are entered only from busy.
- R11: In every serial clock that carries no image bit (padding and initialisation clocks), `data0_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_start | input | 1 | One-cycle start command from the host |
| host_status | output | 2 | Load state: 00 idle, 01 busy, 10 done, 11 error |
| rom_addr | output | ADDR_W | Byte address into the image ROM |
| rom_data | input | 8 | ROM byte at `rom_addr`; must be valid within one clock of an address change |
| ncfg_o | output | 1 | Configuration reset to the target, active low |
| nstatus_i | input | 1 | Target status: low means reset or error, high means ready |
| cdone_i | input | 1 | Target done flag |
| dclk_o | output | 1 | Serial configuration clock |
| data0_o | output | 1 | Serial configuration data |

## Verification
The bench builds the loader with a six-byte image and a 12-clock reset pulse. It uses a 9-clock setup gap, a divide-by-4 serial clock, 10 initialisation clocks and 16 padding clocks. With these values a complete load takes a few hundred cycles. This lets every path run many times within the run budget: normal completion, done raised mid-image, the padding timeout, a mid-stream error with automatic reload, and a slow readiness response from the target. A behavioural target model in the bench captures the serial stream, raises done or error at chosen bit counts, and delays readiness by a random amount. A fresh random image is loaded on every pass.

// File: rtl/cfg_ld_pkg.sv
// Shared types for the serial bitstream loader.
package cfg_ld_pkg;

    // Host-visible status encoding (R10)
    typedef enum logic [1:0] {
        STAT_IDLE = 2'b00,
        STAT_BUSY = 2'b01,
        STAT_DONE = 2'b10,
        STAT_ERR  = 2'b11
    } ld_status_e;

    // Sequencer states
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PULSE,
        LD_WAIT,
        LD_STREAM,
        LD_TAIL,
        LD_INIT,
        LD_DONE,
        LD_ERR
    } ld_state_e;

    // True for states in which the serial clock runs
    function automatic logic clocks_run(ld_state_e s);
        return (s == LD_STREAM) || (s == LD_TAIL) || (s == LD_INIT);
    endfunction

endpackage

// File: rtl/cfg_ld_sync.sv
// Multi-stage synchroniser for asynchronous target pins.
// Assumes each input is a level that stays put for several clocks.
// Each bit has its own reset value, so idle pin levels are reproduced.
module cfg_ld_sync #(
    parameter int               W       = 2,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        // shift the pin level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], d[b]};
        end

        assign q[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/cfg_ld_clkgen.sv
// Serial clock generator.
// A phase counter runs only while the sequencer stays in a clocking state
// across an edge. Otherwise the phase returns to 0, so the clock goes low at
// once on entry or exit. The clock is low during phases 0..HALF-1 and high
// after that. cyc_end marks the last phase of each period.
// Assumes DIV is even and at least 2.
module cfg_ld_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_q,      // clocking in the present state
    input  logic act_d,      // clocking in the next state
    output logic dclk_o,
    output logic cyc_end
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    logic [PH_W-1:0] ph_q;

    // advance the phase while clocking continues, else park it at 0
    always_ff @(posedge clk) begin
        if (!rst_n)                 ph_q <= '0;
        else if (act_q && act_d)    ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        else                        ph_q <= '0;
    end

    assign dclk_o  = act_q && (ph_q >= PH_HALF);
    assign cyc_end = act_q && (ph_q == PH_LAST);
endmodule

// File: rtl/cfg_ld_shreg.sv
// Byte serialiser, LSB first.
// load takes a new byte; shift moves to the next bit and fills with 1.
// last_o is high while the final bit of the byte is being presented.
module cfg_ld_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         bit_o,
    output logic         last_o
);
    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [IDX_W-1:0] idx_q;

    // hold the byte and the index of the bit on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '1;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= din;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {1'b1, sr_q[W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sr_q[0];
    assign last_o = (idx_q == IDX_W'(W - 1));
endmodule

// File: rtl/cfg_loader.sv
// Serial bitstream loader: top level and load sequencer.
// Reads IMAGE_BYTES bytes from ROM and clocks them into the target over the
// passive serial protocol. The target's status and done pins are
// synchronised before use.
// Assumes rom_data follows rom_addr within one clock. The address moves on
// only when a byte is taken, so the ROM then has a full byte time before the
// next one is needed.
module cfg_loader
    import cfg_ld_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int IMAGE_BYTES = 98304,
    parameter int PULSE_CYC   = 400,
    parameter int GAP_CYC     = 250,
    parameter int DCLK_DIV    = 4,
    parameter int INIT_CLKS   = 10,
    parameter int TAIL_CLKS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_start,
    output logic [1:0]        host_status,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic              ncfg_o,
    input  logic              nstatus_i,
    input  logic              cdone_i,
    output logic              dclk_o,
    output logic              data0_o
);
    localparam int TMR_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CNT_MAX = (INIT_CLKS > TAIL_CLKS) ? INIT_CLKS : TAIL_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(IMAGE_BYTES);

    ld_state_e          state_q, state_d;
    logic [TMR_W-1:0]   tmr_q, tmr_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic               seen_low_q, seen_low_d;

    logic [1:0] pins_s;
    logic       nst_s, cdone_s;
    logic       cyc_end, sh_bit, sh_last, sh_load, sh_shift;

    // synchronise target pins; status idles high, done idles low
    cfg_ld_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cdone_i, nstatus_i}),
        .q     (pins_s)
    );
    assign nst_s   = pins_s[0];
    assign cdone_s = pins_s[1];

    cfg_ld_clkgen #(
        .DIV (DCLK_DIV)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_q   (clocks_run(state_q)),
        .act_d   (clocks_run(state_d)),
        .dclk_o  (dclk_o),
        .cyc_end (cyc_end)
    );

    cfg_ld_shreg #(
        .W (8)
    ) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .shift  (sh_shift),
        .din    (rom_data),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    // next-state logic of the load sequencer
    always_comb begin
        state_d    = state_q;
        tmr_d      = tmr_q;
        cnt_d      = cnt_q;
        addr_d     = addr_q;
        seen_low_d = seen_low_q;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        unique case (state_q)
            // R2: accept a start only when not busy
            LD_IDLE, LD_DONE, LD_ERR: begin
                if (host_start) begin
                    state_d    = LD_PULSE;
                    tmr_d      = '0;
                    seen_low_d = 1'b0;
                end
            end
            // R3: hold the reset pulse for PULSE_CYC clocks
            LD_PULSE: begin
                addr_d = '0;
                if (!nst_s) seen_low_d = 1'b1;
                if (tmr_q == TMR_W'(PULSE_CYC - 1)) begin
                    state_d = LD_WAIT;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            // R4: need a low-then-high status and the setup gap
            LD_WAIT: begin
                if (!nst_s) seen_low_d = 1'b1;
                if (tmr_q != TMR_W'(TMR_MAX)) tmr_d = tmr_q + 1'b1;
                if (seen_low_q && nst_s && (tmr_q >= TMR_W'(GAP_CYC))) begin
                    state_d = LD_STREAM;
                    sh_load = 1'b1;
                    addr_d  = addr_q + 1'b1;
                end
            end
            // R6/R7/R8: clock the image, watch done and error
            LD_STREAM: begin
                if (!nst_s) begin
                    state_d    = LD_PULSE;
                    tmr_d      = '0;
                    seen_low_d = 1'b0;
                end else if (cyc_end) begin
                    if (cdone_s) begin
                        state_d = LD_INIT;
                        cnt_d   = '0;
                    end else if (sh_last) begin
                        if (addr_q == END_ADDR) begin
                            state_d = LD_TAIL;
                            cnt_d   = '0;
                        end else begin
                            sh_load = 1'b1;
                            addr_d  = addr_q + 1'b1;
                        end
                    end else begin
                        sh_shift = 1'b1;
                    end
                end
            end
            // R9: bounded padding while waiting for done
            LD_TAIL: begin
                if (!nst_s) begin
                    state_d    = LD_PULSE;
                    tmr_d      = '0;
                    seen_low_d = 1'b0;
                end else if (cyc_end) begin
                    if (cdone_s) begin
                        state_d = LD_INIT;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_W'(TAIL_CLKS - 1)) begin
                        state_d = LD_ERR;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            // R7: extra clocks so the target can initialise
            LD_INIT: begin
                if (cyc_end) begin
                    if (cnt_q == CNT_W'(INIT_CLKS - 1)) state_d = LD_DONE;
                    else                                cnt_d   = cnt_q + 1'b1;
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LD_IDLE;
            tmr_q      <= '0;
            cnt_q      <= '0;
            addr_q     <= '0;
            seen_low_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            tmr_q      <= tmr_d;
            cnt_q      <= cnt_d;
            addr_q     <= addr_d;
            seen_low_q <= seen_low_d;
        end
    end

    // R10: status decode
    always_comb begin
        unique case (state_q)
            LD_IDLE: host_status = STAT_IDLE;
            LD_DONE: host_status = STAT_DONE;
            LD_ERR:  host_status = STAT_ERR;
            default: host_status = STAT_BUSY;
        endcase
    end

    assign rom_addr = addr_q;
    assign ncfg_o   = (state_q != LD_PULSE);
    // R11: non-image clocks carry 1
    assign data0_o  = (state_q == LD_STREAM) ? sh_bit : 1'b1;
endmodule

// File: rtl/cfg_loader_chk.sv
// Protocol checker for cfg_loader, bound to it below.
// Long windows are measured with saturating counters instead of deep $past.
module cfg_loader_chk #(
    parameter int PULSE_CYC = 400,
    parameter int GAP_CYC   = 250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ncfg_o,
    input logic       dclk_o,
    input logic       data0_o,
    input logic [1:0] host_status
);
    int low_cnt, high_cnt;

    // count clocks spent low, and clocks since the last release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= 0;
            high_cnt <= 0;
        end else begin
            low_cnt  <= ncfg_o ? 0 : ((low_cnt < PULSE_CYC) ? low_cnt + 1 : low_cnt);
            high_cnt <= !ncfg_o ? 0 : ((high_cnt < GAP_CYC) ? high_cnt + 1 : high_cnt);
        end
    end

    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ncfg_o) |-> (low_cnt >= PULSE_CYC));

    assert_setup_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> (high_cnt >= GAP_CYC));

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(data0_o));

    assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data0_o) |-> !dclk_o);

    assert_no_clk_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> !dclk_o);

    assert_busy_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ncfg_o |-> (host_status == 2'b01));

    assert_done_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_status == 2'b10) && ($past(host_status) != 2'b10)) |-> ($past(host_status) == 2'b01));

    assert_err_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_status == 2'b11) && ($past(host_status) != 2'b11)) |-> ($past(host_status) == 2'b01));
endmodule

bind cfg_loader cfg_loader_chk #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ncfg_o      (ncfg_o),
    .dclk_o      (dclk_o),
    .data0_o     (data0_o),
    .host_status (host_status)
);

// File: tb/cfg_loader_bench.sv
// Bench for cfg_loader: random images, a behavioural target model, and
// directed corner cases.
module cfg_loader_bench;
    localparam int ADDR_W = 17;
    localparam int IMG    = 6;
    localparam int PULSE  = 12;
    localparam int GAP    = 9;
    localparam int DIV    = 4;
    localparam int INITC  = 10;
    localparam int TAILC  = 16;
    localparam int NBITS  = IMG * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_start = 1'b0;
    logic [1:0]        host_status;
    logic [ADDR_W-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic              ncfg_o, dclk_o, data0_o;
    logic              nstatus_m = 1'b1;
    logic              cdone_m = 1'b0;

    logic [7:0] rom [IMG];
    logic [7:0] cap [IMG];

    assign rom_data = (int'(rom_addr) < IMG) ? rom[int'(rom_addr)] : 8'hFF;

    cfg_loader #(
        .ADDR_W(ADDR_W), .IMAGE_BYTES(IMG), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
        .DCLK_DIV(DIV), .INIT_CLKS(INITC), .TAIL_CLKS(TAILC), .SYNC_STAGES(2)
    ) u_cfg_loader (
        .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_status(host_status),
        .rom_addr(rom_addr), .rom_data(rom_data), .ncfg_o(ncfg_o),
        .nstatus_i(nstatus_m), .cdone_i(cdone_m), .dclk_o(dclk_o), .data0_o(data0_o)
    );

    always #10 clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    // target model configuration
    int cd_mode = 0;      // 0 done after image, 1 never, 2 early
    int early_bits = 0, err_bit = 0, rdy_dly = 3;
    bit err_done = 0;
    // monitor state
    int cyc = 0, rdy_cnt = 0, falls = 0, low_w = 0, last_low_w = 0, hi_since = 0;
    int first_gap = -1, t_ns_rise = -1, t_first_dk = -1, last_rise = 0;
    int bitcnt = 0, rises_run = 0, rises_after_cd = 0, zeros_pad = 0, per_bad = 0;
    bit p_ncfg = 1'b1, p_dclk = 1'b0;

    // target model and stream monitor, evaluated away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!ncfg_o) begin
                if (p_ncfg) begin falls++; low_w = 0; end
                low_w++;
                nstatus_m = 1'b0; cdone_m = 1'b0; rdy_cnt = rdy_dly;
                bitcnt = 0; hi_since = 0; first_gap = -1; t_ns_rise = -1; t_first_dk = -1;
            end else begin
                if (!p_ncfg) last_low_w = low_w;
                hi_since++;
                if (rdy_cnt > 0) begin
                    rdy_cnt--;
                    if (rdy_cnt == 0) begin nstatus_m = 1'b1; t_ns_rise = cyc; end
                end
            end
            if (dclk_o && !p_dclk) begin
                rises_run++;
                if (first_gap < 0) begin first_gap = hi_since; t_first_dk = cyc; end
                else if (cyc - last_rise != DIV) per_bad++;
                last_rise = cyc;
                if (cdone_m) rises_after_cd++;
                if (bitcnt < NBITS) cap[bitcnt / 8][bitcnt % 8] = data0_o;
                else if (!data0_o) zeros_pad++;
                bitcnt++;
                if (cd_mode == 0 && bitcnt == NBITS) cdone_m = 1'b1;
                if (cd_mode == 2 && bitcnt == early_bits) cdone_m = 1'b1;
                if (err_bit > 0 && !err_done && bitcnt == err_bit) begin
                    nstatus_m = 1'b0; err_done = 1'b1;
                end
            end
            p_ncfg = ncfg_o;
            p_dclk = dclk_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_status(input int mode);
        return (mode == 1) ? 3 : 2;
    endfunction

    function automatic int image_mismatches();
        int n = 0;
        for (int i = 0; i < IMG; i++) if (cap[i] !== rom[i]) n++;
        return n;
    endfunction

    // one load with the given target behaviour
    task automatic do_run(input int mode, input int ebit, input int early, input int rdy,
                          input bit extra_start);
        @(negedge clk);
        for (int i = 0; i < IMG; i++) rom[i] = 8'($urandom);
        for (int i = 0; i < IMG; i++) cap[i] = 8'h00;
        cd_mode = mode; err_bit = ebit; early_bits = early; rdy_dly = rdy; err_done = 0;
        falls = 0; rises_run = 0; rises_after_cd = 0; zeros_pad = 0; per_bad = 0;
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        repeat (4) @(negedge clk);
        check(host_status == 2'b01, "R10 busy", int'(host_status), 1);
        if (extra_start) begin
            repeat (25) @(negedge clk);
            host_start = 1'b1;
            @(negedge clk);
            host_start = 1'b0;
        end
        for (int i = 0; i < 4000; i++) begin
            if (host_status == 2'b10 || host_status == 2'b11) break;
            @(negedge clk);
        end
    endtask

    // shared checks for a run that should finish cleanly
    task automatic check_good(input int exp_falls);
        check(host_status == 2'(exp_status(0)), "R7 done status", int'(host_status), 2);
        check(last_low_w == PULSE, "R3 pulse width", last_low_w, PULSE);
        check(first_gap >= GAP, "R4 setup gap", first_gap, GAP);
        check(t_first_dk > t_ns_rise, "R4 clock after ready", t_first_dk, t_ns_rise + 1);
        check(per_bad == 0, "R5 clock period", per_bad, 0);
        check(image_mismatches() == 0, "R6 image LSB first", image_mismatches(), 0);
        check(rises_after_cd >= INITC && rises_after_cd <= INITC + 1, "R7 init clocks",
              rises_after_cd, INITC);
        check(zeros_pad == 0, "R11 padding ones", zeros_pad, 0);
        check(falls == exp_falls, "R2/R8 reset pulses", falls, exp_falls);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < IMG; i++) rom[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(host_status == 2'b00, "R1 idle status", int'(host_status), 0);
        check(ncfg_o == 1'b1, "R1 ncfg high", int'(ncfg_o), 1);
        check(dclk_o == 1'b0, "R1 dclk low", int'(dclk_o), 0);
        repeat (20) @(negedge clk);
        check(falls == 0 && host_status == 2'b00, "R1 no start no action", falls, 0);

        // normal load with a redundant start while busy (R2, R3..R7, R11)
        do_run(0, 0, 0, 3, 1'b1);
        check_good(1);
        // slow readiness from the target (R4)
        do_run(0, 0, 0, 40, 1'b0);
        check_good(1);
        // done never rises: timeout (R9)
        do_run(1, 0, 0, 3, 1'b0);
        check(host_status == 2'b11, "R9 error status", int'(host_status), 3);
        check(rises_run == NBITS + TAILC, "R9 padding count", rises_run, NBITS + TAILC);
        check(zeros_pad == 0, "R11 padding ones", zeros_pad, 0);
        // restart from error, with a mid-stream error (R2, R8)
        do_run(0, 13, 0, 3, 1'b0);
        check_good(2);
        // done raised early in the image (R7)
        do_run(2, 0, 20, 3, 1'b0);
        check(host_status == 2'b10, "R7 early done status", int'(host_status), 2);
        check(rises_after_cd >= INITC && rises_after_cd <= INITC + 1, "R7 early init clocks",
              rises_after_cd, INITC);
        // random passes
        for (int k = 0; k < 6; k++) begin
            int e = ($urandom_range(0, 1) == 1) ? $urandom_range(1, NBITS) : 0;
            do_run(0, e, 0, $urandom_range(1, 30), 1'($urandom_range(0, 1)));
            check_good((e > 0) ? 2 : 1);
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule